// File: doc/BRIEF.md
# Load/Store Ordering Gate

This block keeps every memory operation of an out-of-order core in program order and decides when each one may touch memory. The front end allocates an entry per load or store, in order, and receives the entry index back. Once address generation resolves an operation's registers and computes its effective address, that address is written into the entry by index. The dependence check runs only on known addresses.

A load is released to the data cache only when no older store can alias it. Every older store must already have a known address, and that address must lie in a different word. When several loads qualify in the same cycle, the oldest one is released first. A store never writes speculatively. When the reorder logic commits the store at the queue head, the block raises a write request and holds it until the cache acknowledges, then frees the entry. A committed load at the head frees its entry at once. A flush removes every entry younger than a given index, for recovery from a mispredicted branch or an exception.

Top module: `lsq_dep_check`

## Requirements
- R1: Out of reset the queue is empty, `alloc_ready_o` is 1, `alloc_idx_o` is 0, and neither `ld_grant_o` nor `st_req_o` is asserted.
- R2: Each accepted allocation takes the tail index shown on `alloc_idx_o`, and the tail then advances by one modulo DEPTH. With DEPTH entries held, `alloc_ready_o` is 0 and an allocation request has no effect.
- R3: A load is granted only after its address is known. The grant appears in the cycle after the address update edge and carries the entry index and the stored address. Each load is granted at most once.
- R4: A load is not granted while any older valid store has no known address.
- R5: A load is not granted while an older valid store has the same word address (address bits [31:2] equal, so bits [1:0] are ignored). Younger stores never block it.
- R6: When several loads are eligible in the same cycle, the one nearest the head in program order (counting from the head around the ring) is granted first, and the others follow in later cycles.
- R7: A store raises no write request before it is committed. After `commit_i` while the store is at the head, `st_req_o` rises in the next cycle with its address, and it stays high with a stable address until `st_ack_i`. The ack edge frees the entry.
- R8: `commit_i` while a load is at the head frees that entry at the same edge, so a full queue shows `alloc_ready_o` = 1 in the next cycle.
- R9: `flush_i` with `flush_idx_i` removes every entry younger than that index and moves the tail to the index after it. An allocation in the same cycle is dropped. Removed loads are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate one entry at the tail |
| alloc_is_store_i | input | 1 | 1 = store, 0 = load |
| alloc_ready_o | output | 1 | Queue not full |
| alloc_idx_o | output | 3 | Index the next allocation receives |
| addr_valid_i | input | 1 | Effective address update |
| addr_idx_i | input | 3 | Entry being updated |
| addr_i | input | 32 | Effective byte address |
| commit_i | input | 1 | Commit the head operation |
| flush_i | input | 1 | Drop entries younger than flush_idx_i |
| flush_idx_i | input | 3 | Youngest entry kept |
| ld_grant_o | output | 1 | Load released to the cache this cycle |
| ld_grant_idx_o | output | 3 | Index of the granted load |
| ld_grant_addr_o | output | 32 | Address of the granted load |
| st_req_o | output | 1 | Committed head store requests a write |
| st_addr_o | output | 32 | Address of the head store |
| st_ack_i | input | 1 | Write accepted, frees the head store |

## Verification
All outputs are decoded from registered state, so each result is due in the cycle right after the edge that captures its cause. A load grant shows one cycle after its address update or after the edge that clears its last blocker. A write request shows one cycle after the commit, and a freed slot shows on `alloc_ready_o` one cycle after the commit or ack. The bench drives inputs just after a rising edge and samples at the following falling edge. It places each expected grant in a scoreboard queue before the stimulus that causes it. A monitor pops that queue on every falling edge that shows a grant, and a drain check one falling edge later confirms that nothing expected is missing and nothing extra arrived.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // distance from an older ring position to a younger one
  function automatic int unsigned ring_dist(input int unsigned from_idx,
                                            input int unsigned to_idx,
                                            input int unsigned depth);
    return (to_idx + depth - from_idx) % depth;
  endfunction
endpackage

// File: rtl/lsq_ring_ptr.sv
module lsq_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] flush_idx_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  import lsq_pkg::*;

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  int unsigned      keep;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
    return (32'(v) == DEPTH - 1) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    keep   = ring_dist(32'(head_q), 32'(flush_idx_i), DEPTH) + 1;
    head_d = pop_i ? wrap_inc(head_q) : head_q;
    if (flush_i) begin
      tail_d = wrap_inc(flush_idx_i);
      cnt_d  = CNT_W'(keep) - CNT_W'(pop_i);
    end else begin
      tail_d = push_i ? wrap_inc(tail_q) : tail_q;
      cnt_d  = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lsq_block_matrix.sv
module lsq_block_matrix #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 30,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [DEPTH-1:0]  valid_i,
  input  logic [DEPTH-1:0]  store_i,
  input  logic [DEPTH-1:0]  addr_ok_i,
  input  logic [WORD_W-1:0] word_i [DEPTH],
  output logic [DEPTH-1:0]  blocked_o
);
  import lsq_pkg::*;

  logic [DEPTH-1:0] hit [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      logic older;
      assign older = ring_dist(32'(head_i), j, DEPTH) < ring_dist(32'(head_i), i, DEPTH);
      // older store with unknown or same-word address
      assign hit[i][j] = valid_i[j] && store_i[j] && older &&
                         (!addr_ok_i[j] || (word_i[j] == word_i[i]));
    end
    assign blocked_o[i] = |hit[i];
  end
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    gnt_o = 1'b0;
    idx_o = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDX_W-1:0] pos;
      pos = IDX_W'((32'(head_i) + 32'(k)) % DEPTH);
      if (!gnt_o && req_i[pos]) begin
        gnt_o = 1'b1;
        idx_o = pos;
      end
    end
  end
endmodule

// File: rtl/lsq_dep_check.sv
module lsq_dep_check #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_is_store_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              addr_valid_i,
  input  logic [IDX_W-1:0]  addr_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              commit_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_idx_i,
  output logic              ld_grant_o,
  output logic [IDX_W-1:0]  ld_grant_idx_o,
  output logic [ADDR_W-1:0] ld_grant_addr_o,
  output logic              st_req_o,
  output logic [ADDR_W-1:0] st_addr_o,
  input  logic              st_ack_i
);
  import lsq_pkg::*;

  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int WORD_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, push, pop, commit_ok;
  logic [DEPTH-1:0]  valid_q, store_q, aok_q, issued_q, cmt_q;
  logic [DEPTH-1:0]  blocked, kill, elig;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [WORD_W-1:0] word [DEPTH];
  int unsigned       flush_age;

  assign commit_ok = commit_i && valid_q[head] && !(store_q[head] && cmt_q[head]);
  assign st_req_o  = valid_q[head] && store_q[head] && cmt_q[head];
  assign st_addr_o = addr_q[head];
  assign pop       = (commit_ok && !store_q[head]) || (st_req_o && st_ack_i);
  assign push      = alloc_valid_i && !full && !flush_i;
  assign alloc_ready_o = !full;
  assign alloc_idx_o   = tail;
  assign flush_age = ring_dist(32'(head), 32'(flush_idx_i), DEPTH);

  lsq_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .flush_i     (flush_i),
    .flush_idx_i (flush_idx_i),
    .head_o      (head),
    .tail_o      (tail),
    .count_o     (count),
    .full_o      (full)
  );

  lsq_block_matrix #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_blk (
    .head_i    (head),
    .valid_i   (valid_q),
    .store_i   (store_q),
    .addr_ok_i (aok_q),
    .word_i    (word),
    .blocked_o (blocked)
  );

  lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .req_i  (elig),
    .head_i (head),
    .gnt_o  (ld_grant_o),
    .idx_o  (ld_grant_idx_o)
  );

  assign ld_grant_addr_o = addr_q[ld_grant_idx_o];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign word[i] = addr_q[i][ADDR_W-1:OFF_W];
    assign kill[i] = flush_i && (ring_dist(32'(head), i, DEPTH) > flush_age);
    assign elig[i] = valid_q[i] && !store_q[i] && aok_q[i] && !issued_q[i] && !blocked[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i]  <= 1'b0;
        store_q[i]  <= 1'b0;
        aok_q[i]    <= 1'b0;
        issued_q[i] <= 1'b0;
        cmt_q[i]    <= 1'b0;
        addr_q[i]   <= '0;
      end else if (push && tail == IDX_W'(i)) begin
        valid_q[i]  <= 1'b1;
        store_q[i]  <= alloc_is_store_i;
        aok_q[i]    <= 1'b0;
        issued_q[i] <= 1'b0;
        cmt_q[i]    <= 1'b0;
      end else if (kill[i] || (pop && head == IDX_W'(i))) begin
        valid_q[i]  <= 1'b0;
        aok_q[i]    <= 1'b0;
        issued_q[i] <= 1'b0;
        cmt_q[i]    <= 1'b0;
      end else begin
        if (addr_valid_i && addr_idx_i == IDX_W'(i) && valid_q[i]) begin
          aok_q[i]  <= 1'b1;
          addr_q[i] <= addr_i;
        end
        if (ld_grant_o && ld_grant_idx_o == IDX_W'(i)) issued_q[i] <= 1'b1;
        if (commit_ok && head == IDX_W'(i) && store_q[i]) cmt_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsq_dep_check_chk.sv
module lsq_dep_check_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              alloc_ready_o,
  input logic [IDX_W-1:0]  alloc_idx_o,
  input logic              flush_i,
  input logic              ld_grant_o,
  input logic [IDX_W-1:0]  ld_grant_idx_o,
  input logic              st_req_o,
  input logic [ADDR_W-1:0] st_addr_o,
  input logic              st_ack_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DEPTH-1:0]  valid_i,
  input logic [DEPTH-1:0]  store_i,
  input logic [DEPTH-1:0]  aok_i
);
  logic [IDX_W-1:0] next_idx;
  assign next_idx = (32'(alloc_idx_o) == DEPTH - 1) ? '0 : alloc_idx_o + 1'b1;

  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == '0 |-> !ld_grant_o && !st_req_o); // R1

  AST_ALLOC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && alloc_ready_o && !flush_i |=> alloc_idx_o == $past(next_idx)); // R2

  AST_FULL_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == CNT_W'(DEPTH) |-> !alloc_ready_o); // R2

  AST_GRANT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_grant_o |-> valid_i[ld_grant_idx_o] && !store_i[ld_grant_idx_o] && aok_i[ld_grant_idx_o]); // R3

  AST_GRANT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_grant_o |=> !(ld_grant_o && ld_grant_idx_o == $past(ld_grant_idx_o))); // R3

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_o && !st_ack_i && !flush_i |=> st_req_o && $stable(st_addr_o)); // R7
endmodule

bind lsq_dep_check lsq_dep_check_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_idx_o    (alloc_idx_o),
  .flush_i        (flush_i),
  .ld_grant_o     (ld_grant_o),
  .ld_grant_idx_o (ld_grant_idx_o),
  .st_req_o       (st_req_o),
  .st_addr_o      (st_addr_o),
  .st_ack_i       (st_ack_i),
  .count_i        (count),
  .valid_i        (valid_q),
  .store_i        (store_q),
  .aok_i          (aok_q)
);

// File: tb/lsq_dep_check_test.sv
`timescale 1ns/1ps
module lsq_dep_check_test;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0, alloc_is_store_i = 1'b0;
  logic        alloc_ready_o;
  logic [2:0]  alloc_idx_o;
  logic        addr_valid_i = 1'b0;
  logic [2:0]  addr_idx_i = '0;
  logic [31:0] addr_i = '0;
  logic        commit_i = 1'b0, flush_i = 1'b0;
  logic [2:0]  flush_idx_i = '0;
  logic        ld_grant_o;
  logic [2:0]  ld_grant_idx_o;
  logic [31:0] ld_grant_addr_o;
  logic        st_req_o;
  logic [31:0] st_addr_o;
  logic        st_ack_i = 1'b0;

  always #2 clk = ~clk;

  lsq_dep_check #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_is_store_i(alloc_is_store_i),
    .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
    .addr_valid_i(addr_valid_i), .addr_idx_i(addr_idx_i), .addr_i(addr_i),
    .commit_i(commit_i), .flush_i(flush_i), .flush_idx_i(flush_idx_i),
    .ld_grant_o(ld_grant_o), .ld_grant_idx_o(ld_grant_idx_o),
    .ld_grant_addr_o(ld_grant_addr_o),
    .st_req_o(st_req_o), .st_addr_o(st_addr_o), .st_ack_i(st_ack_i)
  );

  typedef struct { logic [2:0] idx; logic [31:0] addr; string tag; } grant_t;
  grant_t exp_q [$];
  int    n_chk = 0, n_fail = 0;
  string quiet_tag = "R1";
  bit    done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); @(negedge clk); endtask
  task automatic idle(input int n); repeat (n) tick(); endtask

  task automatic expect_grant(input logic [2:0] idx, input logic [31:0] a, input string tag);
    grant_t g;
    g.idx = idx; g.addr = a; g.tag = tag;
    exp_q.push_back(g);
  endtask

  task automatic drained(input string tag);
    @(negedge clk); #1;
    chk({tag, " pending grants"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic do_alloc(input logic st);
    alloc_valid_i = 1'b1; alloc_is_store_i = st; tick(); alloc_valid_i = 1'b0;
  endtask
  task automatic do_addr(input logic [2:0] idx, input logic [31:0] a);
    addr_valid_i = 1'b1; addr_idx_i = idx; addr_i = a; tick(); addr_valid_i = 1'b0;
  endtask
  task automatic do_commit(); commit_i = 1'b1; tick(); commit_i = 1'b0; endtask
  task automatic do_ack(); st_ack_i = 1'b1; tick(); st_ack_i = 1'b0; endtask
  task automatic do_flush(input logic [2:0] idx, input logic with_alloc);
    flush_i = 1'b1; flush_idx_i = idx; alloc_valid_i = with_alloc; alloc_is_store_i = 1'b0;
    tick();
    flush_i = 1'b0; alloc_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: every grant must match the scoreboard head
  always @(negedge clk) begin
    if (rst_ni && ld_grant_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s unexpected grant actual idx=%0d addr=%0h expected none",
                 quiet_tag, ld_grant_idx_o, ld_grant_addr_o);
      end else begin
        grant_t g;
        g = exp_q.pop_front();
        chk({g.tag, " grant idx/addr"}, {ld_grant_idx_o, ld_grant_addr_o[28:0]},
            {g.idx, g.addr[28:0]});
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    tick();
    settle();
    chk("R1 ready", 32'(alloc_ready_o), 32'd1);
    chk("R1 alloc idx", 32'(alloc_idx_o), 32'd0);
    chk("R1 no grant", 32'(ld_grant_o), 32'd0);
    chk("R1 no store req", 32'(st_req_o), 32'd0);

    // program order: L0 S1 L2 S3 L4
    do_alloc(0); do_alloc(1); do_alloc(0); do_alloc(1); do_alloc(0);
    settle();
    chk("R2 tail after five", 32'(alloc_idx_o), 32'd5);
    quiet_tag = "R4";
    do_addr(2, 32'h100); idle(1); drained("R4");
    expect_grant(0, 32'h200, "R3");
    do_addr(0, 32'h200); drained("R3");
    quiet_tag = "R5";
    do_addr(1, 32'h102); idle(1); drained("R5");
    quiet_tag = "R4";
    do_addr(4, 32'h300); idle(1); drained("R4");
    quiet_tag = "R5";
    do_addr(3, 32'h301); idle(1); drained("R5");
    settle();
    chk("R7 no req before commit", 32'(st_req_o), 32'd0);
    do_commit();
    settle();
    chk("R7 load commit gives no req", 32'(st_req_o), 32'd0);
    do_commit();
    settle();
    chk("R7 req after commit", 32'(st_req_o), 32'd1);
    chk("R7 req addr", st_addr_o, 32'h102);
    idle(2); settle();
    chk("R7 req held", 32'(st_req_o), 32'd1);
    chk("R7 addr held", st_addr_o, 32'h102);
    expect_grant(2, 32'h100, "R7");
    do_ack(); drained("R7");
    settle();
    chk("R7 req drops after ack", 32'(st_req_o), 32'd0);
    do_commit(); do_commit();
    settle();
    chk("R7 second store addr", st_addr_o, 32'h301);
    expect_grant(4, 32'h300, "R5");
    do_ack(); drained("R5");
    do_commit();
    settle();
    chk("R2 tail unchanged when empty", 32'(alloc_idx_o), 32'd5);

    // full ring with wrap: S5 then loads 6,7,0..4
    do_alloc(1);
    for (int k = 0; k < 7; k++) do_alloc(0);
    settle();
    chk("R2 full not ready", 32'(alloc_ready_o), 32'd0);
    quiet_tag = "R4";
    do_addr(1, 32'h10); do_addr(6, 32'h20); idle(1); drained("R4");
    do_alloc(0);
    expect_grant(6, 32'h20, "R6");
    expect_grant(1, 32'h10, "R6");
    quiet_tag = "R6";
    do_addr(5, 32'h80); idle(1); drained("R6");
    do_commit(); do_ack();
    settle();
    chk("R2 ready after ack", 32'(alloc_ready_o), 32'd1);
    chk("R2 full alloc ignored", 32'(alloc_idx_o), 32'd5);
    do_alloc(0);
    settle();
    chk("R2 full again", 32'(alloc_ready_o), 32'd0);
    do_commit();
    settle();
    chk("R8 load commit frees", 32'(alloc_ready_o), 32'd1);
    chk("R8 tail", 32'(alloc_idx_o), 32'd6);
    for (int k = 0; k < 7; k++) do_commit();
    settle();
    chk("R8 drained queue no req", 32'(st_req_o), 32'd0);

    // flush: S6 L7 S0 L1
    do_alloc(1); do_alloc(0); do_alloc(1); do_alloc(0);
    quiet_tag = "R4";
    do_addr(1, 32'h400); do_addr(7, 32'h500); idle(1); drained("R4");
    expect_grant(7, 32'h500, "R4");
    do_addr(6, 32'h600); drained("R4");
    quiet_tag = "R9";
    do_flush(7, 1'b1);
    settle();
    chk("R9 tail after flush", 32'(alloc_idx_o), 32'd0);
    idle(2); drained("R9");
    do_alloc(0);
    settle();
    chk("R9 realloc slot", 32'(alloc_idx_o), 32'd1);
    expect_grant(0, 32'h404, "R9");
    do_addr(0, 32'h404); drained("R9");

    idle(2);
    chk("end scoreboard empty", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule